// File: doc/BRIEF.md
# Processor Strap Sequencer

This block sequences the processor configuration strap pins through power-up and the processor's first reset. Its strap bus passes through three phases. While main power is active it drives every strap line high. A fixed number of slow-clock periods after both power-good inputs are valid together, it drives the programmed strap pattern. A fixed number of fast-clock periods after the processor reports that reset is complete, it releases the bus. Each phase change is timed in a different clock domain and is tied to a different system event.

Both clock domains reach the block as single-cycle enables on one system clock. The strap pattern comes from a configuration register input. The cycle in which the pattern is latched also produces a one-cycle strobe that tells the power-management logic to deassert suspend status. After release, a float output tells the pad drivers to let go of the strap lines, and the bus takes a parameterised normal-function value.

Top module: `strap_seq_top`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any clock edge at which `main_pwr` is low, `strap_out` is all zeros, `strap_float` is 0 and `sus_clr` is 0.
- R2: With `main_pwr` high and the two power-good inputs not both high, `strap_out` is all ones and `strap_float` is 0. A slow tick counts only when both power-good inputs are high.
- R3: Let a qualifying tick be a cycle with `slow_tick` high, both power-good inputs high and the bus forced high. After the LAT_TICKS-th qualifying tick, `strap_out` equals the `strap_cfg` value sampled in that tick's cycle, starting in the next cycle. Cycles without a tick do not count.
- R4: `sus_clr` is high for exactly one cycle: the first cycle in which the latched pattern is driven.
- R5: If either power-good input drops while main power is on, in any phase, the bus returns to all ones in the next cycle and `strap_float` is 0. The latch count then restarts from zero.
- R6: Once the pattern is latched, a `rst_done` pulse arms the release. After REL_TICKS `fast_tick` cycles strictly after the pulse, `strap_float` is 1 and `strap_out` equals IDLE_VAL from the next cycle.
- R7: A `rst_done` pulse that arrives before the pattern is latched is ignored. Fast ticks alone never release the bus.
- R8: While the release count runs, a repeated `rst_done` does not restart it. Slow ticks have no effect after the latch.
- R9: Changes on `strap_cfg` after the latch do not change `strap_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_pwr | input | 1 | Main power rail active |
| pgood_a | input | 1 | First power-good input |
| pgood_b | input | 1 | Second power-good input |
| rst_done | input | 1 | Processor reset-complete pulse |
| slow_tick | input | 1 | Slow-clock enable, one cycle per period |
| fast_tick | input | 1 | Fast-clock enable, one cycle per period |
| strap_cfg | input | STRAP_W | Programmed strap pattern |
| strap_out | output | STRAP_W | Strap bus value |
| strap_float | output | 1 | Strap drivers released (float) |
| sus_clr | output | 1 | Suspend-status deassert strobe |

## Verification
The bench builds the block with a 4-bit strap bus, LAT_TICKS of 33, REL_TICKS of 8 and an all-zero IDLE_VAL. The narrow bus lets it sweep all sixteen strap patterns through the full power-up, latch and release sequence. In each pass it counts every slow and fast tick and checks the bus one tick before and at each boundary. It also covers early reset-complete pulses, a repeated pulse during release, power-good loss in the middle of the count and after the latch, and loss of main power.

// File: rtl/strap_seq_pkg.sv
// Shared types for the strap sequencer.
package strap_seq_pkg;
    // Phase of the strap bus; the order follows the power-up sequence.
    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_FORCED = 2'd1,
        PH_LATCH  = 2'd2,
        PH_FREE   = 2'd3
    } strap_phase_t;
endpackage

// File: rtl/strap_tick_counter.sv
// Counts qualified clock-enable ticks and flags the N-th.
// Assumes: clr has priority over counting; done is combinational and
// is high only in the cycle of the N-th qualified tick.
module strap_tick_counter #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic done
);
    localparam int CW = (N < 2) ? 1 : $clog2(N + 1);

    logic [CW-1:0] cnt_q;

    // Terminal tick: enabled, ticking and one short of N.
    assign done = en && tick && !clr && (cnt_q == CW'(N - 1));

    // Advance the count on each qualified tick, clearing on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en && tick) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/strap_phase_fsm.sv
// Phase controller for the strap bus.
// Assumes: pwr and pg_ok are already synchronous to clk; loss of power
// outranks loss of power-good, which outranks every forward transition.
module strap_phase_fsm
    import strap_seq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr,
    input  logic         pg_ok,
    input  logic         lat_done,
    input  logic         rel_done,
    input  logic         rst_done,
    output strap_phase_t phase,
    output logic         rel_armed
);
    strap_phase_t phase_d;
    logic         armed_d;

    // Next-phase and release-arm decisions.
    always_comb begin
        phase_d = phase;
        armed_d = rel_armed;
        if (!pwr) begin
            phase_d = PH_OFF;
            armed_d = 1'b0;
        end else if (!pg_ok) begin
            phase_d = PH_FORCED;
            armed_d = 1'b0;
        end else begin
            unique case (phase)
                PH_OFF:    phase_d = PH_FORCED;
                PH_FORCED: if (lat_done) phase_d = PH_LATCH;
                PH_LATCH: begin
                    if (rel_armed && rel_done) begin
                        phase_d = PH_FREE;
                        armed_d = 1'b0;
                    end else if (rst_done) begin
                        armed_d = 1'b1;
                    end
                end
                PH_FREE:   phase_d = PH_FREE;
                default:   phase_d = PH_OFF;
            endcase
        end
    end

    // Phase and arm registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_OFF;
            rel_armed <= 1'b0;
        end else begin
            phase     <= phase_d;
            rel_armed <= armed_d;
        end
    end
endmodule

// File: rtl/strap_bus_driver.sv
// Holds the latched pattern and forms the strap bus per phase.
// Assumes: cap is high for one cycle, in the cycle the phase enters latch.
module strap_bus_driver
    import strap_seq_pkg::*;
#(
    parameter int              W        = 4,
    parameter logic [W-1:0]    IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  strap_phase_t phase,
    input  logic         cap,
    input  logic [W-1:0] cfg,
    output logic [W-1:0] bus,
    output logic         float_en,
    output logic         strobe
);
    logic [W-1:0] pat_q;
    logic         strobe_q;

    // Capture the pattern and raise the strobe at the latch point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= cap;
            if (cap) pat_q <= cfg;
        end
    end

    // Select the bus value for the current phase.
    always_comb begin
        unique case (phase)
            PH_FORCED: bus = '1;
            PH_LATCH:  bus = pat_q;
            PH_FREE:   bus = IDLE_VAL;
            default:   bus = '0;
        endcase
    end

    assign float_en = (phase == PH_FREE);
    assign strobe   = strobe_q && (phase == PH_LATCH);
endmodule

// File: rtl/strap_seq_top.sv
// Strap sequencer top: forces straps high, latches the pattern after the
// slow-tick delay, releases after the fast-tick delay.
// Assumes: tick enables and level inputs are synchronous to clk.
module strap_seq_top
    import strap_seq_pkg::*;
#(
    parameter int                 STRAP_W   = 4,
    parameter int                 LAT_TICKS = 33,
    parameter int                 REL_TICKS = 8,
    parameter logic [STRAP_W-1:0] IDLE_VAL  = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               main_pwr,
    input  logic               pgood_a,
    input  logic               pgood_b,
    input  logic               rst_done,
    input  logic               slow_tick,
    input  logic               fast_tick,
    input  logic [STRAP_W-1:0] strap_cfg,
    output logic [STRAP_W-1:0] strap_out,
    output logic               strap_float,
    output logic               sus_clr
);
    strap_phase_t phase;
    logic         rel_armed;
    logic         pg_ok;
    logic         lat_en, lat_done;
    logic         rel_en, rel_done;

    assign pg_ok  = pgood_a && pgood_b;
    assign lat_en = main_pwr && pg_ok && (phase == PH_FORCED);
    assign rel_en = main_pwr && pg_ok && rel_armed && (phase == PH_LATCH);

    strap_tick_counter #(.N(LAT_TICKS)) u_lat_cnt (
        .clk(clk), .rst_n(rst_n), .clr(!lat_en), .en(lat_en),
        .tick(slow_tick), .done(lat_done)
    );

    strap_tick_counter #(.N(REL_TICKS)) u_rel_cnt (
        .clk(clk), .rst_n(rst_n), .clr(!rel_en), .en(rel_en),
        .tick(fast_tick), .done(rel_done)
    );

    strap_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr(main_pwr), .pg_ok(pg_ok),
        .lat_done(lat_done), .rel_done(rel_done), .rst_done(rst_done),
        .phase(phase), .rel_armed(rel_armed)
    );

    strap_bus_driver #(.W(STRAP_W), .IDLE_VAL(IDLE_VAL)) u_drv (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cap(lat_done),
        .cfg(strap_cfg), .bus(strap_out), .float_en(strap_float),
        .strobe(sus_clr)
    );
endmodule

// File: rtl/strap_seq_chk.sv
// Port-level properties of the strap sequencer, bound to the top.
module strap_seq_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         main_pwr,
    input logic         pgood_a,
    input logic         pgood_b,
    input logic [W-1:0] strap_cfg,
    input logic [W-1:0] strap_out,
    input logic         strap_float,
    input logic         sus_clr
);
    // R1
    pwr_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_pwr |=> (strap_out == '0) && !strap_float && !sus_clr);

    // R2
    pg_low_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_pwr && !(pgood_a && pgood_b) |=> (strap_out == '1) && !strap_float);

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sus_clr |=> !sus_clr);

    // R3
    latch_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sus_clr) |-> strap_out == $past(strap_cfg));

    // R6
    release_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_float) |-> $past(main_pwr && pgood_a && pgood_b));
endmodule

bind strap_seq_top strap_seq_chk #(.W(STRAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .main_pwr(main_pwr), .pgood_a(pgood_a),
    .pgood_b(pgood_b), .strap_cfg(strap_cfg), .strap_out(strap_out),
    .strap_float(strap_float), .sus_clr(sus_clr)
);

// File: tb/tb_strap_seq_top.sv
module tb_strap_seq_top;
    localparam int          W    = 4;
    localparam int          LAT  = 33;
    localparam int          REL  = 8;
    localparam logic [W-1:0] IDLE = '0;
    localparam logic [W-1:0] ONES = '1;

    logic clk = 0, rst_n = 0, main_pwr = 0, pgood_a = 0, pgood_b = 0;
    logic rst_done = 0, slow_tick = 0, fast_tick = 0;
    logic [W-1:0] strap_cfg = '0, strap_out;
    logic strap_float, sus_clr;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    strap_seq_top #(.STRAP_W(W), .LAT_TICKS(LAT), .REL_TICKS(REL), .IDLE_VAL(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .main_pwr(main_pwr), .pgood_a(pgood_a),
        .pgood_b(pgood_b), .rst_done(rst_done), .slow_tick(slow_tick),
        .fast_tick(fast_tick), .strap_cfg(strap_cfg), .strap_out(strap_out),
        .strap_float(strap_float), .sus_clr(sus_clr));

    task automatic chk(string tag, logic [W+1:0] act, logic [W+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One clock with the given pulses; outputs are sampled at the next negedge.
    task automatic step(logic s, logic f, logic r);
        slow_tick = s; fast_tick = f; rst_done = r;
        @(posedge clk); @(negedge clk);
        slow_tick = 0; fast_tick = 0; rst_done = 0;
    endtask

    function automatic logic [W+1:0] st(logic [W-1:0] b, logic fl, logic su);
        return {b, fl, su};
    endfunction

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); step(0, 0, 0);
        chk("R1 reset", {strap_out, strap_float, sus_clr}, st('0, 0, 0));
        rst_n = 1;
        for (int p = 0; p < (1 << W); p++) begin
            main_pwr = 0; pgood_a = 0; pgood_b = 0; step(0, 0, 0);
            chk("R1 power off", {strap_out, strap_float, sus_clr}, st('0, 0, 0));
            main_pwr = 1; step(0, 0, 0);
            chk("R2 forced", {strap_out, strap_float, sus_clr}, st(ONES, 0, 0));
            pgood_a = (p % 2 == 0); pgood_b = !pgood_a;
            for (int k = 0; k < LAT + 2; k++) step(1, 0, 0);
            chk("R2 one pgood", {strap_out, strap_float, sus_clr}, st(ONES, 0, 0));
            pgood_a = 1; pgood_b = 1;
            strap_cfg = ~W'(p);
            step(0, 1, 1);   // early reset-complete pulse (R7)
            for (int k = 1; k < LAT; k++) begin
                step(1, 0, 0);
                if (k % 4 == 0) step(0, 1, 0);
            end
            chk("R3 before last tick", {strap_out, strap_float, sus_clr}, st(ONES, 0, 0));
            strap_cfg = W'(p);
            step(1, 0, 0);
            chk("R3 R4 latched", {strap_out, strap_float, sus_clr}, st(W'(p), 0, 1));
            strap_cfg = ~W'(p);
            step(1, 0, 0);
            chk("R4 R9 R8 held", {strap_out, strap_float, sus_clr}, st(W'(p), 0, 0));
            for (int k = 0; k < REL + 2; k++) step(1, 1, 0);
            chk("R7 R8 no release", {strap_out, strap_float, sus_clr}, st(W'(p), 0, 0));
            step(0, 1, 1);   // arm; this cycle's tick is not counted
            for (int k = 1; k < REL; k++) step(0, 1, (k == 3));
            chk("R6 R8 before release", {strap_out, strap_float, sus_clr}, st(W'(p), 0, 0));
            step(0, 1, 0);
            chk("R6 released", {strap_out, strap_float, sus_clr}, st(IDLE, 1, 0));
            if (p % 3 == 0) begin
                pgood_b = 0; step(0, 0, 0);
                chk("R5 drop after release", {strap_out, strap_float, sus_clr}, st(ONES, 0, 0));
            end
        end
        // R5: drop in the middle of the latch count restarts it.
        pgood_a = 1; pgood_b = 1; step(0, 0, 0);
        for (int k = 0; k < 20; k++) step(1, 0, 0);
        pgood_a = 0; step(0, 0, 0);
        chk("R5 mid drop", {strap_out, strap_float, sus_clr}, st(ONES, 0, 0));
        pgood_a = 1; strap_cfg = 4'b1010;
        for (int k = 1; k < LAT; k++) step(1, 0, 0);
        chk("R5 restart count", {strap_out, strap_float, sus_clr}, st(ONES, 0, 0));
        step(1, 0, 0);
        chk("R5 R3 latch after restart", {strap_out, strap_float, sus_clr}, st(4'b1010, 0, 1));
        pgood_b = 0; step(0, 0, 0);
        chk("R5 drop when latched", {strap_out, strap_float, sus_clr}, st(ONES, 0, 0));
        main_pwr = 0; step(0, 0, 0);
        chk("R1 power lost", {strap_out, strap_float, sus_clr}, st('0, 0, 0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule